// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer

This block translates 32-bit byte-addressed virtual addresses into physical addresses for a small processor's memory pipeline. It holds one mapping per index in a single block-RAM array. Each word of that array carries a valid flag, the upper virtual page bits that the index does not cover, and the physical page number. A lookup presents a virtual address and, one cycle later, gets back either a hit with the translated address or a miss flag. Operating-system software then handles the miss, fills in the mapping through the write port and retries.

The page offset is never translated; it is copied from the request into the result. A flush input clears every valid flag so that a new task cannot reuse the old task's mappings. The clear walks the array one word per cycle, and a busy output stalls all other traffic while it runs. The same walk runs automatically when reset is released, so no stale contents are ever visible.

Top module: `tlbx_dm_tlb`

## Requirements
- R1: On a hit, lk_paddr[11:0] equals lk_vaddr[11:0] of the request (the page offset passes through unchanged).
- R2: A lookup accepted on a clock edge (lk_req high, busy low) produces lk_done high on the output for exactly the following cycle; lk_done is low otherwise.
- R3: An entry matches when its valid flag is set and its stored tag equals lk_vaddr[31:22] at index lk_vaddr[21:12]; lk_hit is then 1 and lk_paddr = {stored page, lk_vaddr[11:0]}.
- R4: If the indexed entry is invalid or its tag differs, the result has lk_miss=1, lk_hit=0 and lk_paddr=0.
- R5: wr_en with busy low stores the valid flag, tag wr_vpn[19:10] and page wr_ppn at index wr_vpn[9:0], replacing whatever that index held.
- R6: When a write and a lookup address the same index in the same cycle, the write is stored, but the lookup returns the contents from before the write.
- R7: A flush_req sampled with busy low raises busy for exactly 1024 cycles, starting on the next cycle, and leaves every entry invalid.
- R8: While busy is high, lookups produce no result (lk_done stays 0) and writes are discarded.
- R9: After reset is released, busy is high for 1024 cycles, and every lookup afterwards misses until a mapping is written.
- R10: Whenever lk_done is high, exactly one of lk_hit and lk_miss is high; neither is high when lk_done is low.
- R11: A flush_req that arrives while busy is high is ignored; the running clear neither restarts nor grows longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; its release starts the clear walk |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_done | output | 1 | Lookup result valid (one cycle after acceptance) |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Miss exception for software refill |
| lk_paddr | output | 32 | Physical address, zero on a miss |
| wr_en | input | 1 | Install a mapping |
| wr_vpn | input | 20 | Virtual page number of the mapping |
| wr_ppn | input | 20 | Physical page number of the mapping |
| flush_req | input | 1 | Invalidate every entry |
| busy | output | 1 | Clear walk in progress; lookups and writes stall |

## Verification
The hardest case to reach is a collision between traffic and the clear walk. A second flush request, a lookup and a write must each land inside the 1024-cycle busy window. Afterwards the bench must show, at the ports, that none of them changed anything. The bench counts busy cycles at the falling edge. At fixed counts inside the window it injects the extra flush, the lookup and the write. After the walk ends, it reads back the index that the discarded write aimed at. The same-cycle write and lookup to one index is driven in a single cycle, and is followed by a second lookup that shows the new contents.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/tlbx_ram.sv
module tlbx_ram #(
  parameter int DW = 31,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // synchronous read returns the word as it stood before this edge's write
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/tlbx_sweep.sv
module tlbx_sweep
  import tlbx_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          clr_we,
  output logic [AW-1:0] clr_idx
);
  localparam logic [AW-1:0] LAST = '1;

  sweep_state_e  st;
  logic [AW-1:0] idx;
  logic          at_last;

  assign at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SW_RUN;
      idx <= '0;
    end else begin
      unique case (st)
        SW_IDLE: if (start) begin
          st  <= SW_RUN;
          idx <= '0;
        end
        SW_RUN: begin
          if (at_last) st <= SW_IDLE;
          else         idx <= idx + 1'b1;
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  assign busy    = (st == SW_RUN);
  assign clr_we  = busy;
  assign clr_idx = idx;

  // R7
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clr_idx != LAST) |=> (busy && clr_idx == AW'($past(clr_idx) + 1'b1)));
  // R7
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(clr_idx) == LAST));
  // R11
  sweep_norestart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && clr_idx != LAST) |=> (clr_idx != '0));
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match #(
  parameter int TAG_W = 10,
  parameter int PPN_W = 20,
  parameter int OFS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_q,
  input  logic [TAG_W-1:0]       tag_q,
  input  logic [OFS_W-1:0]       off_q,
  input  logic                   ent_valid,
  input  logic [TAG_W-1:0]       ent_tag,
  input  logic [PPN_W-1:0]       ent_ppn,
  output logic                   done,
  output logic                   hit,
  output logic                   miss,
  output logic [PPN_W+OFS_W-1:0] paddr
);
  logic tag_eq;

  assign tag_eq = (ent_tag == tag_q);
  assign done   = req_q;
  assign hit    = req_q & ent_valid & tag_eq;
  assign miss   = req_q & ~(ent_valid & tag_eq);
  assign paddr  = hit ? {ent_ppn, off_q} : '0;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({hit, miss}) == 1));
  // R10
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(hit || miss));
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (paddr == '0));
endmodule

// File: rtl/tlbx_dm_tlb.sv
module tlbx_dm_tlb #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int IDX_W = 10,
  parameter int PPN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_req,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   lk_done,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  input  logic                   wr_en,
  input  logic [VA_W-OFS_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic                   flush_req,
  output logic                   busy
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int ENT_W = 1 + TAG_W + PPN_W;

  // address and entry arithmetic
  function automatic logic [IDX_W-1:0] vpn_idx(input logic [VPN_W-1:0] v);
    return v[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] vpn_tag(input logic [VPN_W-1:0] v);
    return v[VPN_W-1:IDX_W];
  endfunction
  function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] a);
    return a[VA_W-1:OFS_W];
  endfunction
  function automatic logic [OFS_W-1:0] va_off(input logic [VA_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction
  function automatic logic [ENT_W-1:0] pack_ent(input logic [TAG_W-1:0] t,
                                                input logic [PPN_W-1:0] p);
    return {1'b1, t, p};
  endfunction

  // lookup stage registers
  logic             req_q;
  logic [TAG_W-1:0] tag_q;
  logic [OFS_W-1:0] off_q;
  logic             lk_accept;
  logic             wr_accept;

  assign lk_accept = lk_req & ~busy;
  assign wr_accept = wr_en & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tag_q <= '0;
      off_q <= '0;
    end else begin
      req_q <= lk_accept;
      if (lk_accept) begin
        tag_q <= vpn_tag(va_vpn(lk_vaddr));
        off_q <= va_off(lk_vaddr);
      end
    end
  end

  // clear walk
  logic             clr_we;
  logic [IDX_W-1:0] clr_idx;

  tlbx_sweep #(.AW(IDX_W)) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (flush_req),
    .busy    (busy),
    .clr_we  (clr_we),
    .clr_idx (clr_idx)
  );

  // entry array: clear walk owns the write port while it runs
  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [ENT_W-1:0] ram_wdata;
  logic [ENT_W-1:0] ram_rdata;

  assign ram_we    = clr_we | wr_accept;
  assign ram_waddr = clr_we ? clr_idx : vpn_idx(wr_vpn);
  assign ram_wdata = clr_we ? '0 : pack_ent(vpn_tag(wr_vpn), wr_ppn);

  tlbx_ram #(.DW(ENT_W), .AW(IDX_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (vpn_idx(va_vpn(lk_vaddr))),
    .rdata (ram_rdata)
  );

  tlbx_match #(.TAG_W(TAG_W), .PPN_W(PPN_W), .OFS_W(OFS_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_q     (req_q),
    .tag_q     (tag_q),
    .off_q     (off_q),
    .ent_valid (ram_rdata[ENT_W-1]),
    .ent_tag   (ram_rdata[PPN_W +: TAG_W]),
    .ent_ppn   (ram_rdata[PPN_W-1:0]),
    .done      (lk_done),
    .hit       (lk_hit),
    .miss      (lk_miss),
    .paddr     (lk_paddr)
  );

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));
  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $past(lk_req));
  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !lk_done);
endmodule

// File: tb/tlbx_dm_tlb_bench.sv
module tlbx_dm_tlb_bench;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic        lk_done, lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic        wr_en;
  logic [19:0] wr_vpn;
  logic [19:0] wr_ppn;
  logic        flush_req;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4ns clk = ~clk;

  tlbx_dm_tlb u_tlbx_dm_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .flush_req(flush_req), .busy(busy)
  );

  typedef struct packed {
    logic        is_lk;
    logic [31:0] va;
    logic [19:0] ppn;
    logic        hit;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0040_1000, 20'h12345, 1'b0},
    '{1'b1, 32'h0040_1ABC, 20'h12345, 1'b1},
    '{1'b1, 32'h0080_1ABC, 20'h00000, 1'b0},
    '{1'b1, 32'h0040_2000, 20'h00000, 1'b0},
    '{1'b0, 32'h0080_1000, 20'hABCDE, 1'b0},
    '{1'b1, 32'h0080_1FFF, 20'hABCDE, 1'b1},
    '{1'b1, 32'h0040_1000, 20'h00000, 1'b0},
    '{1'b0, 32'hFFFF_F000, 20'hFFFFF, 1'b0},
    '{1'b1, 32'hFFFF_F123, 20'hFFFFF, 1'b1},
    '{1'b0, 32'h0000_0000, 20'h00001, 1'b0},
    '{1'b1, 32'h0000_0FFF, 20'h00001, 1'b1},
    '{1'b1, 32'hFFC0_0000, 20'h00000, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] va, input logic [19:0] ppn);
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = va[31:12]; wr_ppn = ppn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected result packed as {done, hit, miss, paddr}
  function automatic logic [63:0] expect_res(input logic [31:0] va, input logic h,
                                             input logic [19:0] ppn);
    return {29'd0, 1'b1, h, ~h, (h ? {ppn, va[11:0]} : 32'd0)};
  endfunction

  task automatic do_lookup(input string req, input logic [31:0] va,
                           input logic h, input logic [19:0] ppn);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_req = 1'b0;
    check(req, {29'd0, lk_done, lk_hit, lk_miss, lk_paddr}, expect_res(va, h, ppn));
  endtask

  // R7 R8 R11: count busy cycles, injecting traffic mid-walk
  task automatic run_flush(input bit inject, output int cycles);
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    cycles = 0;
    while (busy && cycles < 4 * DEPTH) begin
      cycles++;
      if (inject) begin
        flush_req = (cycles == 100);
        if (cycles == 200) begin lk_req = 1'b1; lk_vaddr = 32'h0080_1000; end
        if (cycles == 201) begin
          lk_req = 1'b0;
          check("R8 lookup while busy", {63'd0, lk_done}, 64'd0);
        end
        wr_en = (cycles == 300);
        wr_vpn = 20'h00007; wr_ppn = 20'h77777;
      end
      @(negedge clk);
    end
    flush_req = 1'b0; wr_en = 1'b0; lk_req = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0; lk_req = 1'b0; lk_vaddr = '0; wr_en = 1'b0;
    wr_vpn = '0; wr_ppn = '0; flush_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 reset outputs", {60'd0, lk_done, lk_hit, lk_miss, busy}, 64'd1);
    rst_n = 1'b1;
    // R9: reset walk length, with a lookup attempted during it
    cyc = 0;
    while (busy && cyc < 4 * DEPTH) begin
      cyc++;
      if (cyc == 10) begin lk_req = 1'b1; lk_vaddr = 32'h0040_1000; end
      if (cyc == 11) begin
        lk_req = 1'b0;
        check("R8 lookup during reset walk", {63'd0, lk_done}, 64'd0);
      end
      @(negedge clk);
    end
    check("R9 reset walk length", 64'(cyc), 64'(DEPTH));
    do_lookup("R9 empty after reset", 32'h0123_4567, 1'b0, 20'd0);

    // vector table: R3 R4 R5 R1
    foreach (VECS[i]) begin
      if (VECS[i].is_lk)
        do_lookup("R3/R4 vector", VECS[i].va, VECS[i].hit, VECS[i].ppn);
      else
        do_write(VECS[i].va, VECS[i].ppn);
    end

    // R6: same-index write and lookup in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = 20'h00005; wr_ppn = 20'h55555;
    lk_req = 1'b1; lk_vaddr = 32'h0000_5ABC;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    check("R6 old contents", {29'd0, lk_done, lk_hit, lk_miss, lk_paddr},
          expect_res(32'h0000_5ABC, 1'b0, 20'd0));
    do_lookup("R6 new contents", 32'h0000_5ABC, 1'b1, 20'h55555);

    // R2: lk_done lasts exactly one cycle
    @(negedge clk);
    check("R2 single-cycle done", {63'd0, lk_done}, 64'd0);

    // R7 + R11 + R8 on flush
    run_flush(1'b1, cyc);
    check("R11 flush length with repeat request", 64'(cyc), 64'(DEPTH));
    do_lookup("R7 entry cleared", 32'h0080_1000, 1'b0, 20'd0);
    do_lookup("R7 entry cleared", 32'h0000_5000, 1'b0, 20'd0);
    do_lookup("R7 last entry cleared", 32'hFFFF_F000, 1'b0, 20'd0);
    do_lookup("R8 write during busy dropped", 32'h0000_7000, 1'b0, 20'd0);

    // refill after flush and plain flush length
    do_write(32'h0000_7000, 20'h00ABC);
    do_lookup("R5 refill after flush", 32'h0000_7001, 1'b1, 20'h00ABC);
    run_flush(1'b0, cyc);
    check("R7 flush length", 64'(cyc), 64'(DEPTH));
    do_lookup("R7 refill cleared", 32'h0000_7001, 1'b0, 20'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule